// File: doc/BRIEF.md
# Six-Stage Pipeline Forwarding and Load Interlock Unit

This unit resolves data hazards for a scalar, in-order pipeline with six stages: fetch, decode, register read, ALU, memory and write-back. Each cycle it takes the source register indices of the instruction sitting in the register-read stage. It compares them against the destination, write-enable and load flag of the two older instructions in the ALU and memory stages. From that comparison it produces a bypass select for every ALU source operand and a one-cycle stall request.

All outputs are registered. A decision made while an instruction is in register read is therefore presented during the cycle that instruction spends in the ALU stage, which is the cycle in which the operand multiplexers use it. A producer three instructions ahead needs no bypass, because the register file writes in write-back before it is read in the same cycle. A load immediately followed by a consumer of its result holds the front four stages for one cycle and inserts a bubble into memory. The consumer then takes the loaded value over the load path.

Top module: `fwd_hazard_unit`

## Requirements
- R1: While `rst` is high at a clock edge, every select becomes 00 and `stall` becomes 0 after that edge.
- R2: If the ALU-stage instruction writes a source's register and is not a load, that operand's select is 01 (ALU result) in the next cycle.
- R3: If only the memory-stage instruction writes a source's register and it is not a load, the select is 10 (memory-stage ALU result) in the next cycle.
- R4: If neither the ALU-stage nor the memory-stage instruction writes a source's register, its select is 00 (register file) in the next cycle. This covers distance three and independent instructions.
- R5: If the ALU-stage instruction is a load that writes a source's register, `stall` is 1 for exactly the next cycle and 0 in the cycle after.
- R6: A load in the memory stage that writes a source's register gives select 11 (load data) in the next cycle with no stall. In the cycle after a stall, an operand hit by the stalling load keeps select 11.
- R7: When both older instructions write the same source register, the ALU-stage (younger) instruction decides the select and any stall.
- R8: With `ZERO_HARD`=1 (default), source register 0 never matches. A producer whose write enable is 0 never matches.
- R9: At the edge that ends a stall cycle, all inputs are ignored. Every operand not hit by the stalling load gets select 00, which means it uses the value latched during the stall cycle.
- R10: Each operand has its own select: operand 0 drives `fwd_sel[1:0]` and operand 1 drives `fwd_sel[3:2]`. The two operands may take different values in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_src | input | NUM_SRC*REG_W | Source register indices of the register-read instruction, operand 0 in the low bits |
| alu_dst | input | REG_W | Destination of the ALU-stage instruction |
| alu_wen | input | 1 | ALU-stage instruction writes a register |
| alu_load | input | 1 | ALU-stage instruction is a load |
| mem_dst | input | REG_W | Destination of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| fwd_sel | output | 2*NUM_SRC | Per-operand bypass select (00 register file, 01 ALU result, 10 memory ALU result, 11 load data) |
| stall | output | 1 | Hold fetch, decode, register read and ALU; bubble into memory |

## Verification
The bench targets the cases where priority decides the outcome. When both older stages write the same register, a design that favours the older one sends a stale value to the ALU and may miss a stall it needs. The stall window is checked to last exactly one cycle. Within that window, inputs that would cause a second stall must be ignored. An operand not fed by the stalling load must fall back to 00, because its bypass source retires during the stall. A design that kept 10 there would read a value that has already left the pipeline. Register 0 and producers with write enable low are also covered, since a false match would forward a value that was never written.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF     = 2'b00,
    FWD_ALU    = 2'b01,
    FWD_MEMALU = 2'b10,
    FWD_LOAD   = 2'b11
  } fwd_sel_e;
endpackage

// File: rtl/fwd_cmp.sv
module fwd_cmp #(
  parameter int REG_W     = 5,
  parameter bit ZERO_HARD = 1'b1
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wen,
  output logic             hit
);
  logic src_zero;
  assign src_zero = (src == '0) && ZERO_HARD;
  assign hit      = wen && (src == dst) && !src_zero;
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import hz_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter bit ZERO_HARD = 1'b1
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] alu_dst,
  input  logic             alu_wen,
  input  logic             alu_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_load,
  output fwd_sel_e         sel,
  output logic             load_near
);
  localparam int NSTG = 2;  // index 0: ALU stage (distance 1), 1: MEM stage (distance 2)

  logic [REG_W-1:0] dst_a  [NSTG];
  logic [NSTG-1:0]  wen_a;
  logic [NSTG-1:0]  hit;

  assign dst_a[0] = alu_dst;
  assign dst_a[1] = mem_dst;
  assign wen_a    = {mem_wen, alu_wen};

  for (genvar s = 0; s < NSTG; s++) begin : g_cmp
    fwd_cmp #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_cmp (
      .src (src),
      .dst (dst_a[s]),
      .wen (wen_a[s]),
      .hit (hit[s])
    );
  end

  // Youngest producer wins
  always_comb begin
    if (hit[0])      sel = alu_load ? FWD_LOAD : FWD_ALU;
    else if (hit[1]) sel = mem_load ? FWD_LOAD : FWD_MEMALU;
    else             sel = FWD_RF;
  end

  assign load_near = hit[0] && alu_load;
endmodule

// File: rtl/fwd_hazard_unit.sv
module fwd_hazard_unit
  import hz_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int NUM_SRC   = 2,
  parameter bit ZERO_HARD = 1'b1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_SRC*REG_W-1:0] rd_src,
  input  logic [REG_W-1:0]         alu_dst,
  input  logic                     alu_wen,
  input  logic                     alu_load,
  input  logic [REG_W-1:0]         mem_dst,
  input  logic                     mem_wen,
  input  logic                     mem_load,
  output logic [2*NUM_SRC-1:0]     fwd_sel,
  output logic                     stall
);
  localparam int SEL_W = 2;

  fwd_sel_e           sel_c [NUM_SRC];
  fwd_sel_e           sel_q [NUM_SRC];
  logic [NUM_SRC-1:0] near_c;
  logic [NUM_SRC-1:0] near_q;
  logic               stall_q;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_op
    fwd_pick #(.REG_W(REG_W), .ZERO_HARD(ZERO_HARD)) u_pick (
      .src       (rd_src[g*REG_W +: REG_W]),
      .alu_dst   (alu_dst),
      .alu_wen   (alu_wen),
      .alu_load  (alu_load),
      .mem_dst   (mem_dst),
      .mem_wen   (mem_wen),
      .mem_load  (mem_load),
      .sel       (sel_c[g]),
      .load_near (near_c[g])
    );
    assign fwd_sel[g*SEL_W +: SEL_W] = sel_q[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stall_q <= 1'b0;
      near_q  <= '0;
      for (int i = 0; i < NUM_SRC; i++) sel_q[i] <= FWD_RF;
    end else if (stall_q) begin
      // Stall cycle ends: inputs ignored, only the stalling-load operands keep the load path
      stall_q <= 1'b0;
      for (int i = 0; i < NUM_SRC; i++) sel_q[i] <= near_q[i] ? FWD_LOAD : FWD_RF;
    end else begin
      stall_q <= |near_c;
      near_q  <= near_c;
      for (int i = 0; i < NUM_SRC; i++) sel_q[i] <= sel_c[i];
    end
  end

  assign stall = stall_q;

  // R5: a stall never lasts longer than one cycle
  a_r5_single_stall: assert property (@(posedge clk) disable iff (rst)
    stall_q |=> !stall_q);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    // R9: after a stall no operand uses a retired ALU-result path
    a_r9_post_stall: assert property (@(posedge clk) disable iff (rst)
      stall_q |=> (sel_q[g] == FWD_RF || sel_q[g] == FWD_LOAD));
    // R2: distance-1 ALU producer selects the ALU result
    a_r2_alu_path: assert property (@(posedge clk) disable iff (rst)
      (!stall_q && alu_wen && !alu_load && alu_dst == rd_src[g*REG_W +: REG_W]
       && !(ZERO_HARD && rd_src[g*REG_W +: REG_W] == '0))
      |=> sel_q[g] == FWD_ALU);
    // R8: hardwired register 0 always reads the register file
    a_r8_zero_reg: assert property (@(posedge clk) disable iff (rst)
      (!stall_q && ZERO_HARD && rd_src[g*REG_W +: REG_W] == '0)
      |=> sel_q[g] == FWD_RF);
  end
endmodule

// File: tb/fwd_hazard_unit_tb.sv
module fwd_hazard_unit_tb;
  localparam int REG_W = 5;
  localparam int NSRC  = 2;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [NSRC*REG_W-1:0] rd_src = '0;
  logic [REG_W-1:0]      alu_dst = '0, mem_dst = '0;
  logic                  alu_wen = 1'b0, alu_load = 1'b0, mem_wen = 1'b0, mem_load = 1'b0;
  logic [2*NSRC-1:0]     fwd_sel;
  logic                  stall;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  fwd_hazard_unit #(.REG_W(REG_W), .NUM_SRC(NSRC), .ZERO_HARD(1'b1)) u_dut (
    .clk(clk), .rst(rst), .rd_src(rd_src),
    .alu_dst(alu_dst), .alu_wen(alu_wen), .alu_load(alu_load),
    .mem_dst(mem_dst), .mem_wen(mem_wen), .mem_load(mem_load),
    .fwd_sel(fwd_sel), .stall(stall)
  );

  typedef struct packed {
    logic [4:0] s0, s1, ad;
    logic       aw, al;
    logic [4:0] md;
    logic       mw, ml;
    logic [1:0] e0, e1;
    logic       es;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [NV] = '{
    '{5'd1,  5'd2,  5'd3,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd4},  // R4 no dependence
    '{5'd3,  5'd2,  5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 4'd2},  // R2 distance 1
    '{5'd2,  5'd4,  5'd7,  1'b1, 1'b0, 5'd4,  1'b1, 1'b0, 2'b00, 2'b10, 1'b0, 4'd3},  // R3 distance 2
    '{5'd5,  5'd5,  5'd5,  1'b1, 1'b0, 5'd5,  1'b1, 1'b0, 2'b01, 2'b01, 1'b0, 4'd7},  // R7 youngest wins
    '{5'd6,  5'd6,  5'd9,  1'b1, 1'b0, 5'd6,  1'b1, 1'b1, 2'b11, 2'b11, 1'b0, 4'd6},  // R6 load distance 2
    '{5'd0,  5'd0,  5'd0,  1'b1, 1'b0, 5'd0,  1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd8},  // R8 register 0
    '{5'd8,  5'd9,  5'd8,  1'b0, 1'b0, 5'd9,  1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 4'd8},  // R8 write enable low
    '{5'd10, 5'd11, 5'd10, 1'b1, 1'b1, 5'd11, 1'b1, 1'b0, 2'b11, 2'b10, 1'b1, 4'd5},  // R5 load-use stall
    '{5'd10, 5'd10, 5'd10, 1'b1, 1'b1, 5'd10, 1'b1, 1'b1, 2'b11, 2'b00, 1'b0, 4'd9},  // R9 ignored, one cycle
    '{5'd12, 5'd13, 5'd12, 1'b1, 1'b0, 5'd13, 1'b1, 1'b1, 2'b01, 2'b11, 1'b0, 4'd10}, // R10 distinct selects
    '{5'd14, 5'd15, 5'd15, 1'b1, 1'b1, 5'd14, 1'b1, 1'b0, 2'b10, 2'b11, 1'b1, 4'd5},  // R5 stall on operand 1
    '{5'd1,  5'd1,  5'd1,  1'b1, 1'b0, 5'd1,  1'b1, 1'b0, 2'b00, 2'b11, 1'b0, 4'd9},  // R9 post-stall
    '{5'd4,  5'd3,  5'd4,  1'b1, 1'b1, 5'd3,  1'b1, 1'b1, 2'b11, 2'b11, 1'b1, 4'd5},  // R5 two loads
    '{5'd3,  5'd3,  5'd3,  1'b1, 1'b0, 5'd3,  1'b1, 1'b0, 2'b11, 2'b00, 1'b0, 4'd6},  // R6 captured load in MEM drops to 00
    '{5'd3,  5'd7,  5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 2'b01, 2'b00, 1'b0, 4'd2},  // R2 resumes after stall
    '{5'd16, 5'd17, 5'd16, 1'b1, 1'b0, 5'd16, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 4'd7}   // R7 ALU beats older load
  };

  task automatic chk(input logic [1:0] act, input logic [1:0] exp, input int rq, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %b expected %b", rq, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    rd_src   = {v.s1, v.s0};
    alu_dst  = v.ad; alu_wen = v.aw; alu_load = v.al;
    mem_dst  = v.md; mem_wen = v.mw; mem_load = v.ml;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    chk(fwd_sel[1:0], 2'b00, 1, "reset sel op0");
    chk(fwd_sel[3:2], 2'b00, 1, "reset sel op1");
    chk({1'b0, stall}, 2'b00, 1, "reset stall");
    @(negedge clk) rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk) drive(TBL[i]);
      @(posedge clk); #1;
      chk(fwd_sel[1:0], TBL[i].e0, int'(TBL[i].rq), $sformatf("row %0d op0", i));
      chk(fwd_sel[3:2], TBL[i].e1, int'(TBL[i].rq), $sformatf("row %0d op1", i));
      chk({1'b0, stall}, {1'b0, TBL[i].es}, int'(TBL[i].rq), $sformatf("row %0d stall", i));
    end

    // R1: reset in the middle of a stall clears it
    @(negedge clk) drive('{5'd20, 5'd21, 5'd20, 1'b1, 1'b1, 5'd21, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 4'd1});
    @(posedge clk); #1;
    chk({1'b0, stall}, 2'b01, 5, "stall before reset");
    @(negedge clk) rst = 1'b1;
    @(posedge clk); #1;
    chk({1'b0, stall}, 2'b00, 1, "stall cleared by reset");
    chk(fwd_sel[1:0], 2'b00, 1, "sel op0 cleared by reset");
    chk(fwd_sel[3:2], 2'b00, 1, "sel op1 cleared by reset");
    @(negedge clk) begin rst = 1'b0; drive('0); end
    @(posedge clk); #1;
    chk({1'b0, stall}, 2'b00, 4, "idle after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule